// File: doc/BRIEF.md
# Stereo Serial Audio Word Receiver

This block takes a stereo audio stream carried on three wires — a data line, a shift clock and a left/right select — and turns it into parallel 20-bit samples for the interpolation path that follows. The shift clock runs at 64 times the sample rate, so each channel gets a 32-bit slot. The select line is high during the left slot and low during the right slot. Each word sits at the start of its slot, and the bits that follow the word inside the slot are don't-care. All three serial wires are oversampled by the core clock `clk_i` through synchronizers. Data is taken on the rising edge of the shift clock.

Two control bits choose the bit order (MSB first or LSB first) and the word length (16 or 20 bits). A 16-bit word is widened by placing it in the upper 16 bits of the 20-bit sample. Every completed word is shown on a per-channel word port with a one-cycle strobe. A left/right pair is then released together on the frame outputs when the right word of the frame completes. The active-low `init_ni` input holds the receiver idle. Its clearing action takes effect only on transitions of the left/right select. Reception restarts at the first select transition after `init_ni` rises.

Top module: `stereo_ser_rx`

## Requirements
- R1: While `rst_ni` is low, `word_o`, `left_o` and `right_o` are all zero, and `word_stb_o` and `frame_stb_o` are low.
- R2: With `lsb_first_i`=0 and `short_word_i`=0, the first bit after a left/right transition is the sign bit (bit 19) of a 20-bit two's-complement word, and `word_o` equals that word.
- R3: With `lsb_first_i`=1, the first bit of the slot is bit 0 of the word, and the last bit of the word is the sign bit.
- R4: With `short_word_i`=1, 16 bits are received and `word_o` equals {word[15:0], 4'b0000}, for either bit order.
- R5: Slot bits after the selected word length have no effect on `word_o`, `left_o` or `right_o`.
- R6: `word_left_o` is 1 for a word received while `lrck_i` was high and 0 for a word received while it was low.
- R7: `word_stb_o` is a one-cycle pulse, given exactly once per received slot, and only after the last bit of the word.
- R8: When the right word that follows a left word completes, `left_o` and `right_o` update together, and `frame_stb_o` pulses for one cycle in the cycle after that word's `word_stb_o`. Outside such updates the frame outputs hold their values.
- R9: A right word that is not preceded by a left word since reception started gives `word_stb_o` but no `frame_stb_o`, and leaves the frame outputs unchanged.
- R10: `lsb_first_i` and `short_word_i` are sampled at the start of each slot. A change in the middle of a slot affects only later slots.
- R11: While `init_ni` is low, no word is received. The frame outputs clear to zero at the next `lrck_i` transition, and they hold their values while `lrck_i` does not toggle.
- R12: After `init_ni` rises, reception starts with the slot that begins at the next `lrck_i` transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the serial wires |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_ni | input | 1 | Active-low receiver initialise, honoured on left/right transitions |
| sclk_i | input | 1 | Shift clock, 64 times the sample rate |
| lrck_i | input | 1 | Left/right select: 1 = left slot, 0 = right slot |
| sdata_i | input | 1 | Serial audio data |
| lsb_first_i | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| short_word_i | input | 1 | Word length: 0 = 20 bits, 1 = 16 bits |
| word_o | output | 20 | Most recently received word |
| word_left_o | output | 1 | Channel of `word_o`: 1 = left |
| word_stb_o | output | 1 | One-cycle pulse when a word completes |
| left_o | output | 20 | Left sample of the last complete frame |
| right_o | output | 20 | Right sample of the last complete frame |
| frame_stb_o | output | 1 | One-cycle pulse when `left_o` and `right_o` update |

## Verification
The main path is driven in all four combinations of bit order and word length. Sign-bit, all-ones, single-bit and asymmetric patterns expose bit reversal, dropped or shifted bits and wrong zero fill. Random filler after each word shows whether out-of-word bits leak into the sample. A format flip in the middle of a slot separates per-slot latching from live sampling of the control bits. An `init_ni` sequence with the select line idle, then toggling, then a lone right slot after release shows the clear condition, the restart point and the suppression of half-filled frames.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SAMPLE_W = 20;
  localparam int SHORT_W  = 16;

  typedef struct packed {
    logic                left;
    logic [SAMPLE_W-1:0] data;
  } sample_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES:0][W-1:0] pipe;
  assign pipe[0] = d_i;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe[s] <= '0;
      else         pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES];
endmodule

// File: rtl/srx_slot.sv
module srx_slot
  import srx_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  logic    slot_start_i,
  input  logic    lr_i,
  input  logic    bit_stb_i,
  input  logic    bit_i,
  input  logic    lsb_first_i,
  input  logic    short_i,
  output sample_t word_o,
  output logic    word_stb_o
);
  localparam int CNT_W = $clog2(SLOT_BITS + 1);
  localparam int PAD_W = SAMPLE_W - SHORT_W;

  logic                armed_q, ch_q, lsb_q, short_q;
  logic [CNT_W-1:0]    cnt_q, wlen;
  logic [SAMPLE_W-1:0] acc_q, acc_nx, just_nx;

  assign wlen    = short_q ? CNT_W'(SHORT_W) : CNT_W'(SAMPLE_W);
  assign acc_nx  = lsb_q ? {bit_i, acc_q[SAMPLE_W-1:1]} : {acc_q[SAMPLE_W-2:0], bit_i};
  // MSB-first short words land low; move them up. LSB-first ones already sit high.
  assign just_nx = (!lsb_q && short_q) ? (acc_nx << PAD_W) : acc_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      ch_q       <= 1'b0;
      lsb_q      <= 1'b0;
      short_q    <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      word_o     <= '0;
      word_stb_o <= 1'b0;
    end else begin
      word_stb_o <= 1'b0;
      if (!run_i) begin
        armed_q <= 1'b0;
      end else if (slot_start_i) begin
        armed_q <= 1'b1;
        ch_q    <= lr_i;
        lsb_q   <= lsb_first_i;
        short_q <= short_i;
        cnt_q   <= '0;
        acc_q   <= '0;
      end else if (bit_stb_i && armed_q && cnt_q < CNT_W'(SLOT_BITS)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < wlen) acc_q <= acc_nx;
        if (cnt_q == wlen - 1'b1) begin
          word_stb_o  <= 1'b1;
          word_o.left <= ch_q;
          word_o.data <= just_nx;
        end
      end
    end
  end
endmodule

// File: rtl/srx_pair.sv
module srx_pair
  import srx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                word_stb_i,
  input  sample_t             word_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                frame_stb_o
);
  logic [SAMPLE_W-1:0] pend_q;
  logic                pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      pend_v_q    <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      frame_stb_o <= 1'b0;
    end else begin
      frame_stb_o <= 1'b0;
      if (clear_i) begin
        pend_q   <= '0;
        pend_v_q <= 1'b0;
        left_o   <= '0;
        right_o  <= '0;
      end else if (word_stb_i) begin
        if (word_i.left) begin
          pend_q   <= word_i.data;
          pend_v_q <= 1'b1;
        end else begin
          pend_v_q <= 1'b0;
          if (pend_v_q) begin
            left_o      <= pend_q;
            right_o     <= word_i.data;
            frame_stb_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stereo_ser_rx.sv
module stereo_ser_rx
  import srx_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_ni,
  input  logic                sclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  input  logic                lsb_first_i,
  input  logic                short_word_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                word_left_o,
  output logic                word_stb_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                frame_stb_o
);
  logic [3:0] sync_q;
  logic       run, dat, lr, sck;
  logic       lr_prev_q, sck_prev_q;
  logic       bit_stb, lr_edge;
  sample_t    word;

  srx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({init_ni, sdata_i, lrck_i, sclk_i}),
    .q_o   (sync_q)
  );
  assign {run, dat, lr, sck} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      lr_prev_q  <= lr;
      sck_prev_q <= sck;
    end
  end

  assign bit_stb = sck & ~sck_prev_q;
  assign lr_edge = lr ^ lr_prev_q;

  srx_slot #(.SLOT_BITS(SLOT_BITS)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .slot_start_i(lr_edge),
    .lr_i        (lr),
    .bit_stb_i   (bit_stb),
    .bit_i       (dat),
    .lsb_first_i (lsb_first_i),
    .short_i     (short_word_i),
    .word_o      (word),
    .word_stb_o  (word_stb_o)
  );

  srx_pair u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (lr_edge & ~run),
    .word_stb_i (word_stb_o),
    .word_i     (word),
    .left_o     (left_o),
    .right_o    (right_o),
    .frame_stb_o(frame_stb_o)
  );

  assign word_o      = word.data;
  assign word_left_o = word.left;
endmodule

// File: rtl/stereo_ser_rx_chk.sv
module stereo_ser_rx_chk
  import srx_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                init_ni,
  input logic                lrck_i,
  input logic                word_stb_o,
  input logic                word_left_o,
  input logic                frame_stb_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o
);
  p_word_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |=> !word_stb_o);

  p_frame_after_right_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> ($past(word_stb_o) && !$past(word_left_o)));

  p_frame_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |=> !frame_stb_o);

  p_frame_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_stb_o && init_ni && $past(init_ni) && $past(init_ni, 2) && $past(init_ni, 3))
      |-> ($stable(left_o) && $stable(right_o)));

  p_channel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> (word_left_o == lrck_i));

  p_idle_in_init_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_ni && !$past(init_ni) && !$past(init_ni, 2) && !$past(init_ni, 3)) |-> !word_stb_o);
endmodule

bind stereo_ser_rx stereo_ser_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_ni    (init_ni),
  .lrck_i     (lrck_i),
  .word_stb_o (word_stb_o),
  .word_left_o(word_left_o),
  .frame_stb_o(frame_stb_o),
  .left_o     (left_o),
  .right_o    (right_o)
);

// File: tb/stereo_ser_rx_test.sv
module stereo_ser_rx_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_ni = 1'b0;
  logic        sclk_i = 1'b0;
  logic        lrck_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic        lsb_first_i = 1'b0;
  logic        short_word_i = 1'b0;
  logic [19:0] word_o, left_o, right_o;
  logic        word_left_o, word_stb_o, frame_stb_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [20:0] word_q[$];
  logic [39:0] pair_q[$];
  logic [39:0] last_pair = '0;

  always #10 clk_i = ~clk_i;

  stereo_ser_rx uut (
    .clk_i, .rst_ni, .init_ni, .sclk_i, .lrck_i, .sdata_i,
    .lsb_first_i, .short_word_i, .word_o, .word_left_o, .word_stb_o,
    .left_o, .right_o, .frame_stb_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] expand(input logic [19:0] v, input bit short);
    return short ? {v[15:0], 4'h0} : v;
  endfunction

  // Monitor: compare strobed results against the queues.
  always @(negedge clk_i) begin
    if (rst_ni && word_stb_o) begin
      if (word_q.size() == 0) check("R7 unexpected word", {43'b0, word_left_o, word_o}, 64'h0);
      else check("R2-R6 word", {43'b0, word_left_o, word_o}, {43'b0, word_q.pop_front()});
    end
    if (rst_ni && frame_stb_o) begin
      if (pair_q.size() == 0) check("R9 unexpected frame", {24'b0, left_o, right_o}, 64'h0);
      else check("R8 frame", {24'b0, left_o, right_o}, {24'b0, pair_q.pop_front()});
    end
  end

  task automatic send_slot(input bit left, input logic [19:0] v, input bit expect_w, input bit flip);
    bit cur_lsb   = lsb_first_i;
    bit cur_short = short_word_i;
    int wl        = cur_short ? 16 : 20;
    lrck_i = left;
    if (expect_w) word_q.push_back({left, expand(v, cur_short)});
    for (int i = 0; i < 32; i++) begin
      if (i < wl) sdata_i = cur_lsb ? v[i] : v[wl-1-i];
      else        sdata_i = 1'($urandom); // R5 filler
      repeat (4) @(negedge clk_i);
      sclk_i = 1'b1;
      if (flip && i == 6) begin
        lsb_first_i  = ~cur_lsb;  // R10 mid-slot change
        short_word_i = ~cur_short;
      end
      repeat (4) @(negedge clk_i);
      sclk_i = 1'b0;
    end
    lsb_first_i  = cur_lsb;
    short_word_i = cur_short;
  endtask

  task automatic send_frame(input logic [19:0] l, input logic [19:0] r);
    last_pair = {expand(l, short_word_i), expand(r, short_word_i)};
    pair_q.push_back(last_pair);
    send_slot(1'b1, l, 1'b1, 1'b0);
    send_slot(1'b0, r, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    check("R1 reset word", {44'b0, word_o}, 64'h0);
    check("R1 reset frame", {24'b0, left_o, right_o}, 64'h0);
    check("R1 reset strobes", {62'b0, word_stb_o, frame_stb_o}, 64'h0);
    rst_ni = 1'b1;
    init_ni = 1'b1;
    repeat (10) @(negedge clk_i);

    // R2 MSB first, 20 bit
    send_frame(20'h12345, 20'hABCDE);
    send_frame(20'h80000, 20'h7FFFF);
    send_frame(20'hFFFFF, 20'h00001);
    // R3 LSB first, 20 bit
    lsb_first_i = 1'b1;
    send_frame(20'h12345, 20'h80001);
    send_frame(20'h00001, 20'hC0000);
    // R4 16 bit, both orders
    short_word_i = 1'b1;
    send_frame(20'h0F00F, 20'h08001);
    lsb_first_i = 1'b0;
    send_frame(20'h01234, 20'h0FFFF);
    send_frame(20'h08000, 20'h00001);
    // R10 format flip mid-slot, latched at slot start
    short_word_i = 1'b0;
    last_pair = {20'h3C5A1, 20'h6E2D9};
    pair_q.push_back(last_pair);
    send_slot(1'b1, 20'h3C5A1, 1'b1, 1'b1);
    send_slot(1'b0, 20'h6E2D9, 1'b1, 1'b1);

    repeat (200) @(negedge clk_i);
    check("R8 hold while idle", {24'b0, left_o, right_o}, {24'b0, last_pair});
    // R11 init low with idle select: outputs hold
    init_ni = 1'b0;
    repeat (60) @(negedge clk_i);
    check("R11 hold without lrck", {24'b0, left_o, right_o}, {24'b0, last_pair});
    // R11 select toggling: no words, outputs clear
    send_slot(1'b1, 20'h11111, 1'b0, 1'b0);
    send_slot(1'b0, 20'h22222, 1'b0, 1'b0);
    check("R11 clear on lrck", {24'b0, left_o, right_o}, 64'h0);
    send_slot(1'b1, 20'h33333, 1'b0, 1'b0);
    // R12 release; R9 lone right slot
    init_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    send_slot(1'b0, 20'h5A5A5, 1'b1, 1'b0);
    check("R9 no frame on lone right", {24'b0, left_o, right_o}, 64'h0);
    send_frame(20'h76543, 20'h89ABC);
    repeat (50) @(negedge clk_i);
    check("R7 words drained", 64'(word_q.size()), 64'h0);
    check("R8 frames drained", 64'(pair_q.size()), 64'h0);
    check("R8 final frame", {24'b0, left_o, right_o}, {24'b0, 20'h76543, 20'h89ABC});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule